// File: doc/BRIEF.md
# Ordered Store Buffer with Type-Aware Forwarding

This block sits between a core's commit stage and the memory side. Committed stores enter through a ready/valid handshake and are kept in a circular queue. They leave for memory one at a time from the oldest slot. Each store carries an address, a data word, per-byte enables and a two-bit memory-type tag. Because only the oldest entry is ever offered, no store can overtake an older one, and an uncached store holds back everything younger than itself.

Younger loads probe the buffer with an address, a byte mask and their own memory type. The answer comes back combinationally in the same cycle, as one of three outcomes. A hit returns the forwarded bytes. A wait tells the load to retry later. If neither is raised, nothing in the buffer overlaps the load and it may read memory. The youngest overlapping store decides the outcome. An uncached store never feeds an uncached load, and a store whose byte enables do not cover the load's mask cannot feed it either.

Two fence inputs are level requests that the core holds until the block lowers its busy flag. While the write fence is busy, forwarding is off and new stores are refused. The full fence adds one more condition: it also waits for the core's earlier loads to finish.

Top module: `stbuf_top`

## Requirements
- R1: After reset the buffer is empty: `mem_valid` is 0, `st_ready` is 1 and `fence_busy` is 0 while no fence is requested.
- R2: Stores are offered on the memory port strictly in the order they were accepted, each with the address, data, byte enables and type it was accepted with.
- R3: The buffer holds DEPTH (default 8) stores. With DEPTH stores held, `st_ready` is 0.
- R4: A lookup whose youngest overlapping store is of a forwardable type and covers every byte of `ld_be` gives `ld_hit`=1 and `ld_wait`=0 in the same cycle. `ld_data` then carries that store's bytes in the lanes set in `ld_be` and zero in the other lanes. Byte lane i is bits 8i+7..8i. Two accesses overlap when their addresses are equal and their byte masks share a set bit.
- R5: When several buffered stores overlap a lookup, only the youngest one decides hit, wait and data.
- R6: Type code 0 is uncached; codes 1, 2 and 3 are write-combining, write-back and write-through. If the youngest overlapping store and the load are both uncached, the result is `ld_wait`=1 and `ld_hit`=0. Every other type pair may forward.
- R7: If the youngest overlapping store's byte enables miss any byte in `ld_be`, the result is `ld_wait`=1 and `ld_hit`=0.
- R8: A lookup that overlaps no buffered store gives `ld_hit`=0 and `ld_wait`=0.
- R9: While `wfence` is high and the buffer is not empty, `fence_busy` is 1, `st_ready` is 0, `ld_hit` is 0 and every lookup gets `ld_wait`=1. `fence_busy` drops in the first cycle the buffer is empty.
- R10: `ffence` behaves as in R9, and in addition keeps `fence_busy` at 1 while `ld_pending` is 1, even when the buffer is empty.
- R11: While `mem_valid` is 1 and `mem_ready` is 0, the offered store stays valid and unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Committed store offered |
| st_ready | output | 1 | Buffer accepts the store this cycle |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_mtype | input | 2 | Store memory type (0 UC, 1 WC, 2 WB, 3 WT) |
| ld_req | input | 1 | Forwarding lookup request |
| ld_addr | input | AW | Load word address |
| ld_be | input | DW/8 | Bytes read by the load |
| ld_mtype | input | 2 | Load memory type |
| ld_hit | output | 1 | Data forwarded from the buffer |
| ld_wait | output | 1 | Load must retry later |
| ld_data | output | DW | Forwarded bytes, zero outside ld_be |
| wfence | input | 1 | Write fence held by the core |
| ffence | input | 1 | Full fence held by the core |
| ld_pending | input | 1 | Earlier loads still outstanding |
| fence_busy | output | 1 | Requested fence not yet satisfied |
| mem_valid | output | 1 | Oldest store offered to memory |
| mem_ready | input | 1 | Memory side takes the offered store |
| mem_addr | output | AW | Offered store address |
| mem_data | output | DW | Offered store data |
| mem_be | output | DW/8 | Offered store byte enables |
| mem_mtype | output | 2 | Offered store memory type |

## Verification
Lookup results, `st_ready`, `fence_busy` and the memory-port fields are combinational functions of the current inputs and the stored state. They are therefore due in the same cycle as the stimulus. The bench drives inputs after a falling edge and compares these outputs one time step later, before the next rising edge. A store accepted or drained at a rising edge changes the buffer only from the following cycle on. The bench's reference queue pushes and pops at that same edge, so every later comparison sees the state the design should hold.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

   typedef enum logic [1:0] {
      MT_UC = 2'd0,
      MT_WC = 2'd1,
      MT_WB = 2'd2,
      MT_WT = 2'd3
   } mtype_e;

   // only an uncached store feeding an uncached load is barred
   function automatic logic fwd_type_ok(input mtype_e st_t, input mtype_e ld_t);
      return !((st_t == MT_UC) && (ld_t == MT_UC));
   endfunction

endpackage

// File: rtl/stbuf_fifo.sv
module stbuf_fifo #(
   parameter int DEPTH = 8,
   parameter int AW    = 16,
   parameter int DW    = 32,
   localparam int NB   = DW / 8,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic [NB-1:0] push_be,
   input  logic [1:0]    push_mtype,
   input  logic          pop,
   output logic [AW-1:0] head_addr,
   output logic [DW-1:0] head_data,
   output logic [NB-1:0] head_be,
   output logic [1:0]    head_mtype,
   output logic          empty,
   output logic          full,
   output logic [PW:0]   cnt,
   output logic [PW-1:0] rd_ptr,
   output logic [AW-1:0] ent_addr  [DEPTH],
   output logic [DW-1:0] ent_data  [DEPTH],
   output logic [NB-1:0] ent_be    [DEPTH],
   output logic [1:0]    ent_mtype [DEPTH]
);

   logic [PW-1:0] wr_q, rd_q;
   logic [PW:0]   cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + 1'b1;
         if (pop)  rd_q <= rd_q + 1'b1;
         if (push && !pop)      cnt_q <= cnt_q + 1'b1;
         else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         ent_addr[wr_q]  <= push_addr;
         ent_data[wr_q]  <= push_data;
         ent_be[wr_q]    <= push_be;
         ent_mtype[wr_q] <= push_mtype;
      end
   end

   assign head_addr  = ent_addr[rd_q];
   assign head_data  = ent_data[rd_q];
   assign head_be    = ent_be[rd_q];
   assign head_mtype = ent_mtype[rd_q];
   assign empty      = (cnt_q == '0);
   assign full       = (cnt_q == (PW+1)'(DEPTH));
   assign cnt        = cnt_q;
   assign rd_ptr     = rd_q;

endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd
   import stbuf_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int AW     = 16,
   parameter int DW     = 32,
   parameter bit FWD_EN = 1'b1,
   localparam int NB    = DW / 8,
   localparam int PW    = $clog2(DEPTH)
) (
   input  logic [AW-1:0] ent_addr  [DEPTH],
   input  logic [DW-1:0] ent_data  [DEPTH],
   input  logic [NB-1:0] ent_be    [DEPTH],
   input  logic [1:0]    ent_mtype [DEPTH],
   input  logic [PW-1:0] rd_ptr,
   input  logic [PW:0]   cnt,
   input  logic [AW-1:0] ld_addr,
   input  logic [NB-1:0] ld_be,
   input  logic [1:0]    ld_mtype,
   output logic          fwd_hit,
   output logic          fwd_wait,
   output logic [DW-1:0] fwd_data
);

   logic          found;
   logic [DW-1:0] sel_data;
   logic [NB-1:0] sel_be;
   logic [1:0]    sel_mt;

   // walk oldest to youngest; the last overlap found is the youngest
   always_comb begin
      found    = 1'b0;
      sel_data = '0;
      sel_be   = '0;
      sel_mt   = '0;
      for (int k = 0; k < DEPTH; k++) begin
         logic [PW-1:0] idx;
         idx = rd_ptr + PW'(k);
         if (((PW+1)'(k) < cnt) && (ent_addr[idx] == ld_addr) &&
             |(ent_be[idx] & ld_be)) begin
            found    = 1'b1;
            sel_data = ent_data[idx];
            sel_be   = ent_be[idx];
            sel_mt   = ent_mtype[idx];
         end
      end
   end

   logic          covers, type_ok;
   logic [DW-1:0] lane_mask;

   assign covers  = ((ld_be & ~sel_be) == '0);
   assign type_ok = fwd_type_ok(mtype_e'(sel_mt), mtype_e'(ld_mtype));

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign lane_mask[8*b +: 8] = {8{ld_be[b]}};
   end

   if (FWD_EN) begin : g_fwd
      assign fwd_hit  = found && covers && type_ok;
      assign fwd_wait = found && !(covers && type_ok);
      assign fwd_data = fwd_hit ? (sel_data & lane_mask) : '0;
   end else begin : g_nofwd
      // every overlap waits for the drain
      assign fwd_hit  = 1'b0;
      assign fwd_wait = found;
      assign fwd_data = '0;
   end

endmodule

// File: rtl/stbuf_fence.sv
module stbuf_fence (
   input  logic wfence,
   input  logic ffence,
   input  logic buf_empty,
   input  logic ld_pending,
   output logic busy
);

   logic wr_part, rd_part;

   assign wr_part = (wfence || ffence) && !buf_empty;
   assign rd_part = ffence && ld_pending;
   assign busy    = wr_part || rd_part;

endmodule

// File: rtl/stbuf_top.sv
module stbuf_top #(
   parameter int DEPTH  = 8,
   parameter int AW     = 16,
   parameter int DW     = 32,
   parameter bit FWD_EN = 1'b1,
   localparam int NB    = DW / 8,
   localparam int PW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          st_valid,
   output logic          st_ready,
   input  logic [AW-1:0] st_addr,
   input  logic [DW-1:0] st_data,
   input  logic [NB-1:0] st_be,
   input  logic [1:0]    st_mtype,
   input  logic          ld_req,
   input  logic [AW-1:0] ld_addr,
   input  logic [NB-1:0] ld_be,
   input  logic [1:0]    ld_mtype,
   output logic          ld_hit,
   output logic          ld_wait,
   output logic [DW-1:0] ld_data,
   input  logic          wfence,
   input  logic          ffence,
   input  logic          ld_pending,
   output logic          fence_busy,
   output logic          mem_valid,
   input  logic          mem_ready,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_data,
   output logic [NB-1:0] mem_be,
   output logic [1:0]    mem_mtype
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("stbuf_top: DEPTH must be a power of two >= 2");
   end
   if (DW < 8 || (DW % 8) != 0) begin : g_bad_dw
      $error("stbuf_top: DW must be a whole number of bytes");
   end
   if (AW < 1) begin : g_bad_aw
      $error("stbuf_top: AW must be positive");
   end

   logic          buf_empty, buf_full, push, pop;
   logic [PW:0]   buf_cnt;
   logic [PW-1:0] rd_ptr;
   logic [AW-1:0] ent_addr  [DEPTH];
   logic [DW-1:0] ent_data  [DEPTH];
   logic [NB-1:0] ent_be    [DEPTH];
   logic [1:0]    ent_mtype [DEPTH];
   logic          fwd_hit, fwd_wait;
   logic [DW-1:0] fwd_data;

   stbuf_fence u_fence (
      .wfence     (wfence),
      .ffence     (ffence),
      .buf_empty  (buf_empty),
      .ld_pending (ld_pending),
      .busy       (fence_busy)
   );

   assign st_ready  = !buf_full && !fence_busy;
   assign push      = st_valid && st_ready;
   assign mem_valid = !buf_empty;
   assign pop       = mem_valid && mem_ready;

   stbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push),
      .push_addr  (st_addr),
      .push_data  (st_data),
      .push_be    (st_be),
      .push_mtype (st_mtype),
      .pop        (pop),
      .head_addr  (mem_addr),
      .head_data  (mem_data),
      .head_be    (mem_be),
      .head_mtype (mem_mtype),
      .empty      (buf_empty),
      .full       (buf_full),
      .cnt        (buf_cnt),
      .rd_ptr     (rd_ptr),
      .ent_addr   (ent_addr),
      .ent_data   (ent_data),
      .ent_be     (ent_be),
      .ent_mtype  (ent_mtype)
   );

   stbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .FWD_EN(FWD_EN)) u_fwd (
      .ent_addr  (ent_addr),
      .ent_data  (ent_data),
      .ent_be    (ent_be),
      .ent_mtype (ent_mtype),
      .rd_ptr    (rd_ptr),
      .cnt       (buf_cnt),
      .ld_addr   (ld_addr),
      .ld_be     (ld_be),
      .ld_mtype  (ld_mtype),
      .fwd_hit   (fwd_hit),
      .fwd_wait  (fwd_wait),
      .fwd_data  (fwd_data)
   );

   assign ld_hit  = ld_req && !fence_busy && fwd_hit;
   assign ld_wait = ld_req && (fence_busy || fwd_wait);
   assign ld_data = ld_hit ? fwd_data : '0;

endmodule

// File: rtl/stbuf_chk.sv
module stbuf_chk #(
   parameter int DEPTH = 8,
   parameter int AW    = 16,
   parameter int DW    = 32,
   localparam int NB   = DW / 8,
   localparam int PW   = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          st_ready,
   input logic          ld_hit,
   input logic          ld_wait,
   input logic          wfence,
   input logic          ffence,
   input logic          ld_pending,
   input logic          fence_busy,
   input logic          mem_valid,
   input logic          mem_ready,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_data,
   input logic [NB-1:0] mem_be,
   input logic [1:0]    mem_mtype,
   input logic [PW:0]   buf_cnt
);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_cnt == (PW+1)'(DEPTH)) |-> !st_ready); // R3

   AST_HIT_WAIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_hit && ld_wait)); // R4

   AST_FENCE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      fence_busy |-> (!ld_hit && !st_ready)); // R9

   AST_DRAIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (wfence && $fell(fence_busy)) |-> !mem_valid); // R9

   AST_FULL_FENCE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (ffence && ld_pending) |-> fence_busy); // R10

   AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
         $stable(mem_data) && $stable(mem_be) && $stable(mem_mtype))); // R11

endmodule

bind stbuf_top stbuf_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/stbuf_top_tb.sv
module stbuf_top_tb;

   localparam int DEPTH = 8;
   localparam int AW    = 16;
   localparam int DW    = 32;
   localparam int NB    = DW / 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_valid = 1'b0, ld_req = 1'b0;
   logic [AW-1:0] st_addr = '0, ld_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic [NB-1:0] st_be = '0, ld_be = '0;
   logic [1:0]    st_mtype = '0, ld_mtype = '0;
   logic          wfence = 1'b0, ffence = 1'b0, ld_pending = 1'b0, mem_ready = 1'b0;
   logic          st_ready, ld_hit, ld_wait, fence_busy, mem_valid;
   logic [DW-1:0] ld_data, mem_data;
   logic [AW-1:0] mem_addr;
   logic [NB-1:0] mem_be;
   logic [1:0]    mem_mtype;

   int n_chk = 0;
   int n_bad = 0;

   logic [AW-1:0] qa[$];
   logic [DW-1:0] qd[$];
   logic [NB-1:0] qb[$];
   logic [1:0]    qm[$];

   always #4 clk = ~clk;

   stbuf_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   function automatic logic exp_busy();
      return ((wfence || ffence) && qa.size() > 0) || (ffence && ld_pending);
   endfunction

   // one cycle: inputs already driven after a falling edge
   task automatic cyc();
      logic busy, erdy, eh, ew, acc_st, acc_mem;
      logic [DW-1:0] ed;
      int   last, nmatch;
      string tag;
      #1;
      busy = exp_busy();
      erdy = (qa.size() < DEPTH) && !busy;
      chk("R3/R9 st_ready", 64'(st_ready), 64'(erdy));
      chk("R9/R10 fence_busy", 64'(fence_busy), 64'(busy));
      chk("R1/R2 mem_valid", 64'(mem_valid), 64'(qa.size() > 0));
      if (qa.size() > 0)
         chk("R2/R11 head", {mem_mtype, mem_be, mem_addr, mem_data},
             {qm[0], qb[0], qa[0], qd[0]});
      if (ld_req) begin
         last = -1; nmatch = 0;
         foreach (qa[i])
            if (qa[i] == ld_addr && (qb[i] & ld_be) != '0) begin
               last = i; nmatch++;
            end
         eh = 1'b0; ew = 1'b0; ed = '0;
         if (busy) begin
            ew = 1'b1; tag = "R9 lookup under fence";
         end else if (last < 0) begin
            tag = "R8 no overlap";
         end else if (qm[last] == 2'd0 && ld_mtype == 2'd0) begin
            ew = 1'b1; tag = "R6 uncached pair";
         end else if ((ld_be & ~qb[last]) != '0) begin
            ew = 1'b1; tag = "R7 partial cover";
         end else begin
            eh = 1'b1;
            for (int b = 0; b < NB; b++)
               if (ld_be[b]) ed[8*b +: 8] = qd[last][8*b +: 8];
            tag = (nmatch > 1) ? "R5 youngest match" : "R4 forward";
         end
         chk(tag, {ld_hit, ld_wait, ld_data}, {eh, ew, ed});
      end
      acc_st  = st_valid && erdy;
      acc_mem = (qa.size() > 0) && mem_ready;
      @(posedge clk);
      if (acc_mem) begin
         void'(qa.pop_front()); void'(qd.pop_front());
         void'(qb.pop_front()); void'(qm.pop_front());
      end
      if (acc_st) begin
         qa.push_back(st_addr); qd.push_back(st_data);
         qb.push_back(st_be);   qm.push_back(st_mtype);
      end
      @(negedge clk);
   endtask

   task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [NB-1:0] be, input logic [1:0] mt);
      st_valid = 1'b1; st_addr = a; st_data = d; st_be = be; st_mtype = mt;
      cyc();
      st_valid = 1'b0;
   endtask

   task automatic look(input logic [AW-1:0] a, input logic [NB-1:0] be, input logic [1:0] mt);
      ld_req = 1'b1; ld_addr = a; ld_be = be; ld_mtype = mt;
      cyc();
      ld_req = 1'b0;
   endtask

   initial begin
      #(8 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset mem_valid", 64'(mem_valid), 64'(0));
      chk("R1 reset st_ready", 64'(st_ready), 64'(1));
      chk("R1 reset fence_busy", 64'(fence_busy), 64'(0));
      rst_n = 1'b1;
      cyc();

      // directed: fill with memory stalled
      mem_ready = 1'b0;
      put(16'h0005, 32'hA1A2A3A4, 4'hF, 2'd2);
      put(16'h0007, 32'hC1C2C3C4, 4'hF, 2'd0);
      put(16'h0005, 32'hB1B2B3B4, 4'h3, 2'd1);
      put(16'h0009, 32'h11223344, 4'hC, 2'd3);
      for (int i = 0; i < 4; i++) put(16'h0100 + 16'(i), 32'(i), 4'hF, 2'd2);
      st_valid = 1'b1; cyc(); cyc(); st_valid = 1'b0;      // R3: full
      look(16'h0005, 4'hF, 2'd2);   // R7
      look(16'h0005, 4'h3, 2'd2);   // R5
      look(16'h0005, 4'h1, 2'd0);   // R5 WC store to UC load
      look(16'h0007, 4'hF, 2'd0);   // R6
      look(16'h0007, 4'h6, 2'd2);   // R4 UC store to WB load
      look(16'h0009, 4'h8, 2'd0);   // R4 WT store
      look(16'h0009, 4'h3, 2'd2);   // R8 no byte overlap
      look(16'h0042, 4'hF, 2'd1);   // R8
      // R11: stall, then R9 write fence drains
      cyc();
      wfence = 1'b1;
      look(16'h0009, 4'h8, 2'd2);
      mem_ready = 1'b1;
      while (exp_busy()) begin st_valid = 1'b1; cyc(); end
      st_valid = 1'b0;
      cyc();
      wfence = 1'b0;
      // R10: full fence waits on loads with an empty buffer
      ffence = 1'b1; ld_pending = 1'b1;
      cyc(); cyc();
      ld_pending = 1'b0;
      cyc();
      ffence = 1'b0;

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         st_valid  = ($urandom % 3) != 0;
         st_addr   = 16'($urandom % 4);
         st_data   = $urandom;
         st_be     = 4'($urandom % 15 + 1);
         st_mtype  = 2'($urandom % 4);
         ld_req    = ($urandom % 2) != 0;
         ld_addr   = 16'($urandom % 4);
         ld_be     = 4'($urandom % 15 + 1);
         ld_mtype  = 2'($urandom % 4);
         mem_ready = ($urandom % 4) == 0;
         ld_pending = ($urandom % 3) == 0;
         if (!wfence && !ffence && ($urandom % 50) == 0) begin
            if ($urandom % 2) wfence = 1'b1; else ffence = 1'b1;
         end
         cyc();
         if ((wfence || ffence) && !exp_busy()) begin
            wfence = 1'b0; ffence = 1'b0;
         end
      end
      summary();
   end

endmodule